// File: doc/BRIEF.md
# Flash Program and Erase Timing Sequencer

This block sets the timing of every write and erase pulse sent to a flash array. A free-running divider turns the system clock into a slow timing tick, selected so that the tick rate lies between 257 kHz and 476 kHz. Every phase of an operation is a fixed number of those ticks. The block supports four operations: a single program, a block program of up to 64 items, a segment erase and a mass erase. A mass erase may be issued again as many times as the caller needs to build up erase time. The block drives three enables toward the array: program, erase and high voltage.

A command is taken only while the sequencer is idle. It then waits for the next timing tick before any enable rises. In block mode the first item arrives with the command. Later items are offered through a ready/valid pair. If an item is late, the sequencer parks with high voltage still on. A finish request, or reaching the 64-item limit, closes the block with a short end phase. A command issued while the block is busy does not run. Instead it sets a sticky violation flag, which software clears by writing a one.

Top module: `flash_pe_seq`

## Requirements
- R1: The timing tick occurs once every `div_val`+1 system cycles, so `div_val` values 0 to 63 give division ratios 1 to 64. Every phase length below is counted in these tick periods.
- R2: A command with `cmd_valid` high while idle is accepted, and `busy` is high from the next cycle. `cmd_op` encodes the operation: 0 for single program, 1 for block, 2 for segment erase, 3 for mass erase. For a single program, `pgm_en` first rises at the next timing tick and stays high for exactly 35 tick periods, with `hv_en` high throughout.
- R3: A segment erase holds `ers_en` high for exactly 4819 tick periods.
- R4: A mass erase holds `ers_en` high for exactly 5297 tick periods and can be issued again once the previous one has finished.
- R5: In a block, the first item holds `pgm_en` for 30 tick periods and each later item for 21. When every item arrives in time, `pgm_en` stays high without a gap.
- R6: `word_ready` is high during a block when no item is waiting, no finish has been requested, fewer than 64 items have been taken, and the end phase has not started. A `data_valid` pulse while `word_ready` is high takes one item.
- R7: If no item is waiting when a block slot ends, `pgm_en` drops while `hv_en` stays high. The next slot starts at the first timing tick after an item arrives.
- R8: A `blk_end` pulse during a block, at any point before the end phase, lets the current slot finish. An end phase of 6 tick periods follows, with `hv_en` high and `pgm_en` low, and then the block returns to idle.
- R9: After 64 items have been taken, `word_ready` stays low, and the end phase follows the last slot without any `blk_end`.
- R10: `cmd_valid` while busy starts nothing and sets `viol` from the next cycle. `viol` stays set until a `viol_clr` pulse, and a set in the same cycle as a clear wins.
- R11: `pgm_en` and `ers_en` are never high together. Whenever either one is high, `hv_en` and `busy` are also high.
- R12: `busy` falls in the cycle after the final tick of an operation. In that same cycle `done` is high for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_val | input | 6 | Divider setting; the ratio is div_val+1 |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Operation code: 0 single, 1 block, 2 segment erase, 3 mass erase |
| data_valid | input | 1 | Next block item supplied |
| blk_end | input | 1 | Request to finish the block |
| viol_clr | input | 1 | Write-one-to-clear for viol |
| busy | output | 1 | Operation in progress |
| word_ready | output | 1 | Block can take another item |
| pgm_en | output | 1 | Program enable to the array |
| ers_en | output | 1 | Erase enable to the array |
| hv_en | output | 1 | High-voltage enable to the array |
| viol | output | 1 | Sticky access-violation flag |
| done | output | 1 | One-cycle completion pulse |

## Verification
Every output is a register, so a stimulus applied in a cycle shows up at the ports in the next cycle: `busy` after a command, `viol` after a command that arrives while busy, and `word_ready` after an item is taken. Enable edges instead wait for the next timing tick, so they come 1 to `div_val`+1 cycles after a command or item. The bench runs a behavioural model on the same clock edges. It compares all seven outputs at every falling edge, while the inputs are stable. It also measures enable pulse widths in system cycles and compares them with the tick counts times `div_val`+1.

// File: rtl/flash_pe_seq.sv
module flash_pe_seq #(
  parameter int DIV_W    = 6,
  parameter int WORD_CYC = 35,
  parameter int BLK_FIRST = 30,
  parameter int BLK_NEXT = 21,
  parameter int BLK_END  = 6,
  parameter int SEG_CYC  = 4819,
  parameter int MASS_CYC = 5297,
  parameter int BLK_MAX  = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_val,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic             data_valid,
  input  logic             blk_end,
  input  logic             viol_clr,
  output logic             busy,
  output logic             word_ready,
  output logic             pgm_en,
  output logic             ers_en,
  output logic             hv_en,
  output logic             viol,
  output logic             done
);
  localparam int LONGEST = (MASS_CYC > SEG_CYC) ? MASS_CYC : SEG_CYC;
  localparam int CW  = $clog2(LONGEST + 1);
  localparam int WCW = $clog2(BLK_MAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_PEND, S_RUN, S_WAIT, S_END} st_t;

  st_t            st;
  logic [1:0]     op;
  logic [DIV_W-1:0] dcnt;
  logic [CW-1:0]  cnt, lim;
  logic [WCW-1:0] words;
  logic           first, pend, endreq;

  wire tick  = dcnt >= div_val;
  wire block = op == 2'd1;
  wire last  = tick && cnt == lim - 1'b1;
  wire full  = words >= WCW'(BLK_MAX);

  assign busy       = st != S_IDLE;
  assign word_ready = busy && block && st != S_END && !pend && !endreq && !full;
  assign pgm_en     = st == S_RUN && !op[1];
  assign ers_en     = st == S_RUN && op[1];
  assign hv_en      = st == S_RUN || st == S_WAIT || st == S_END;

  always_comb begin
    if (st == S_END) lim = CW'(BLK_END);
    else case (op)
      2'd0:    lim = CW'(WORD_CYC);
      2'd1:    lim = first ? CW'(BLK_FIRST) : CW'(BLK_NEXT);
      2'd2:    lim = CW'(SEG_CYC);
      default: lim = CW'(MASS_CYC);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      op     <= 2'd0;
      dcnt   <= '0;
      cnt    <= '0;
      words  <= '0;
      first  <= 1'b0;
      pend   <= 1'b0;
      endreq <= 1'b0;
      viol   <= 1'b0;
      done   <= 1'b0;
    end else begin
      dcnt <= tick ? '0 : dcnt + 1'b1;
      done <= 1'b0;

      if (cmd_valid && busy) viol <= 1'b1;
      else if (viol_clr)     viol <= 1'b0;

      if (word_ready && data_valid) begin
        pend  <= 1'b1;
        words <= words + 1'b1;
      end
      if (busy && block && st != S_END && blk_end) endreq <= 1'b1;

      case (st)
        S_IDLE: if (cmd_valid) begin
          st     <= S_PEND;
          op     <= cmd_op;
          words  <= WCW'(1);
          pend   <= 1'b0;
          endreq <= 1'b0;
          first  <= 1'b1;
        end
        S_PEND: if (tick) begin
          st  <= S_RUN;
          cnt <= '0;
        end
        S_RUN: if (tick) begin
          if (!last) cnt <= cnt + 1'b1;
          else if (!block) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else begin
            first <= 1'b0;
            cnt   <= '0;
            if (pend)                pend <= 1'b0;
            else if (endreq || full) st   <= S_END;
            else                     st   <= S_WAIT;
          end
        end
        S_WAIT: if (tick) begin
          cnt <= '0;
          if (pend) begin
            st   <= S_RUN;
            pend <= 1'b0;
          end else if (endreq) st <= S_END;
        end
        S_END: if (tick) begin
          if (last) begin
            st   <= S_IDLE;
            done <= 1'b1;
          end else cnt <= cnt + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/flash_pe_seq_chk.sv
module flash_pe_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic viol_clr,
  input logic busy,
  input logic word_ready,
  input logic pgm_en,
  input logic ers_en,
  input logic hv_en,
  input logic viol,
  input logic done
);
  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(pgm_en && ers_en));
  p_strobe_hv_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (pgm_en || ers_en) |-> (hv_en && busy));
  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !busy) |=> (busy && !hv_en));
  p_viol_set_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && busy) |=> viol);
  p_viol_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (viol && !viol_clr) |=> viol);
  p_done_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  p_done_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !hv_en));
  p_ready_blk_r6: assert property (@(posedge clk) disable iff (!rst_n)
    word_ready |-> (busy && !ers_en));
endmodule

bind flash_pe_seq flash_pe_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .viol_clr(viol_clr),
  .busy(busy), .word_ready(word_ready), .pgm_en(pgm_en), .ers_en(ers_en),
  .hv_en(hv_en), .viol(viol), .done(done)
);

// File: tb/flash_pe_seq_tb_top.sv
`timescale 1ns/1ps
module flash_pe_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [5:0] div_val = 6'd0;
  logic cmd_valid = 0, data_valid = 0, blk_end = 0, viol_clr = 0;
  logic [1:0] cmd_op = 2'd0;
  logic busy, word_ready, pgm_en, ers_en, hv_en, viol, done;

  always #10 clk = ~clk;

  flash_pe_seq dut_i (
    .clk(clk), .rst_n(rst_n), .div_val(div_val), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .data_valid(data_valid), .blk_end(blk_end),
    .viol_clr(viol_clr), .busy(busy), .word_ready(word_ready),
    .pgm_en(pgm_en), .ers_en(ers_en), .hv_en(hv_en), .viol(viol), .done(done)
  );

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 pending, 2 slot, 3 parked, 4 closing
  int m_div = 0, m_ph = 0, m_op = 0, m_left = 0, m_words = 0;
  bit m_pend = 0, m_endreq = 0, m_viol = 0, m_done = 0;

  function automatic int slot_len(input int o, input bit is_first);
    case (o)
      0: return 35;
      1: return is_first ? 30 : 21;
      2: return 4819;
      default: return 5297;
    endcase
  endfunction

  function automatic bit m_rdy();
    return m_ph != 0 && m_ph != 4 && m_op == 1 && !m_pend && !m_endreq && m_words < 64;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_div <= 0; m_ph <= 0; m_op <= 0; m_left <= 0; m_words <= 0;
      m_pend <= 0; m_endreq <= 0; m_viol <= 0; m_done <= 0;
    end else begin
      automatic bit t = m_div >= int'(div_val);
      m_div  <= t ? 0 : m_div + 1;
      m_done <= 0;
      if (cmd_valid && m_ph != 0) m_viol <= 1;
      else if (viol_clr) m_viol <= 0;
      if (m_rdy() && data_valid) begin m_pend <= 1; m_words <= m_words + 1; end
      if (m_op == 1 && m_ph >= 1 && m_ph <= 3 && blk_end) m_endreq <= 1;
      if (m_ph == 0 && cmd_valid) begin
        m_ph <= 1; m_op <= int'(cmd_op); m_words <= 1; m_pend <= 0; m_endreq <= 0;
      end else if (t) begin
        if (m_ph == 1) begin
          m_ph <= 2; m_left <= slot_len(m_op, 1);
        end else if (m_ph == 2) begin
          if (m_left > 1) m_left <= m_left - 1;
          else if (m_op != 1) begin m_ph <= 0; m_done <= 1; end
          else if (m_pend) begin m_left <= 21; m_pend <= 0; end
          else if (m_endreq || m_words >= 64) begin m_ph <= 4; m_left <= 6; end
          else m_ph <= 3;
        end else if (m_ph == 3) begin
          if (m_pend) begin m_ph <= 2; m_left <= 21; m_pend <= 0; end
          else if (m_endreq) begin m_ph <= 4; m_left <= 6; end
        end else if (m_ph == 4) begin
          if (m_left > 1) m_left <= m_left - 1;
          else begin m_ph <= 0; m_done <= 1; end
        end
      end
    end
  end

  // Per-cycle comparison and pulse-width measurement, away from the active edge
  int p_run = 0, p_last = 0, e_run = 0, e_last = 0;
  always @(negedge clk) if (rst_n) begin
    automatic bit eb = m_ph != 0;
    automatic bit ep = m_ph == 2 && m_op < 2;
    automatic bit ee = m_ph == 2 && m_op >= 2;
    automatic bit eh = m_ph >= 2;
    n_cmp++;
    if (busy !== eb || pgm_en !== ep || ers_en !== ee || hv_en !== eh ||
        word_ready !== m_rdy() || viol !== m_viol || done !== m_done) begin
      n_bad++;
      if (busy !== eb) $display("FAIL R2 busy: actual %0b expected %0b at %0t", busy, eb, $time);
      if (pgm_en !== ep) $display("FAIL R5 pgm_en: actual %0b expected %0b at %0t", pgm_en, ep, $time);
      if (ers_en !== ee) $display("FAIL R3 ers_en: actual %0b expected %0b at %0t", ers_en, ee, $time);
      if (hv_en !== eh) $display("FAIL R7 hv_en: actual %0b expected %0b at %0t", hv_en, eh, $time);
      if (word_ready !== m_rdy()) $display("FAIL R6 word_ready: actual %0b expected %0b at %0t", word_ready, m_rdy(), $time);
      if (viol !== m_viol) $display("FAIL R10 viol: actual %0b expected %0b at %0t", viol, m_viol, $time);
      if (done !== m_done) $display("FAIL R12 done: actual %0b expected %0b at %0t", done, m_done, $time);
    end
    if (pgm_en) p_run++; else if (p_run != 0) begin p_last = p_run; p_run = 0; end
    if (ers_en) e_run++; else if (e_run != 0) begin e_last = e_run; e_run = 0; end
  end

  task automatic cyc(input int n); repeat (n) @(negedge clk); endtask
  task automatic issue(input int o);
    @(negedge clk); cmd_valid = 1; cmd_op = 2'(o);
    @(negedge clk); cmd_valid = 0;
  endtask
  task automatic pulse_end();
    @(negedge clk); blk_end = 1; @(negedge clk); blk_end = 0;
  endtask
  task automatic feed(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      while (!word_ready) @(negedge clk);
      data_valid = 1;
      @(negedge clk); data_valid = 0;
    end
  endtask
  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
    cyc(1);
  endtask

  initial begin
    cyc(3);
    chk(busy === 0 && hv_en === 0 && viol === 0 && done === 0, "R2 reset", busy, 0);
    @(negedge clk); rst_n = 1;

    issue(0); wait_idle();
    chk(p_last == 35, "R2 single width div1", p_last, 35);
    div_val = 6'd3; issue(0); wait_idle();
    chk(p_last == 140, "R1 single width div4", p_last, 140);

    div_val = 6'd1; issue(1); feed(3); pulse_end(); wait_idle();
    chk(p_last == 186, "R5 block of four", p_last, 186);

    div_val = 6'd0; issue(1); cyc(50);
    chk(hv_en === 1 && pgm_en === 0 && busy === 1, "R7 parked", {hv_en, pgm_en}, 2);
    feed(1); pulse_end(); wait_idle();
    chk(p_last == 21, "R7 resumed slot", p_last, 21);

    issue(1); feed(63); cyc(5);
    chk(word_ready === 0, "R9 limit reached", word_ready, 0);
    wait_idle();
    chk(p_last == 1353, "R9 full block width", p_last, 1353);

    div_val = 6'd7; issue(1); pulse_end(); wait_idle();
    chk(p_last == 240, "R8 end during pending", p_last, 240);

    div_val = 6'd0; issue(2); wait_idle();
    chk(e_last == 4819, "R3 segment erase", e_last, 4819);
    issue(3); wait_idle();
    chk(e_last == 5297, "R4 mass erase first", e_last, 5297);
    issue(3); wait_idle();
    chk(e_last == 5297, "R4 mass erase repeat", e_last, 5297);

    issue(0); issue(2); cyc(1);
    chk(viol === 1, "R10 violation set", viol, 1);
    wait_idle();
    chk(viol === 1 && e_last == 5297, "R10 ignored command", viol, 1);
    @(negedge clk); viol_clr = 1; @(negedge clk); viol_clr = 0;
    chk(viol === 0, "R10 cleared", viol, 0);
    issue(0);
    @(negedge clk); cmd_valid = 1; viol_clr = 1;
    @(negedge clk); cmd_valid = 0; viol_clr = 0;
    chk(viol === 1, "R10 set beats clear", viol, 1);
    wait_idle();
    chk(p_last == 35, "R11 single after violation", p_last, 35);

    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_cmp++; n_bad++;
      $display("FAIL R12 watchdog: actual %0d expected %0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule